// File: doc/BRIEF.md
# I2C Master Host-Side Command and Receive Queues

This block is the host-facing data path of an I2C master controller. Software writes a combined data/command register to queue bus operations. Each entry is either a byte to transmit or a request to receive one byte. The bus engine takes entries from the head of the transmit queue with a valid/pop handshake. The engine pushes every received byte into a receive queue, and software drains that queue by reading the same data/command register.

The block generates the two service conditions. "Transmit low" asserts while the command queue holds no more entries than a programmable threshold. "Receive ready" asserts while the receive queue holds more bytes than its own threshold. It also gives one-cycle event pulses for a dropped command, a dropped received byte and a read of an empty receive queue. Software can read the fill level of each queue, both thresholds, a status word and a build-parameter word that reports the queue depths. An abort input from the bus engine empties both queues at once.

Top module: `i2cq_host_if`

## Requirements
- R1: A host write to offset 0x10 queues the 9-bit value `reg_wdata_i[8:0]`. Bit 8 set marks a receive request and bit 8 clear marks a transmit byte in bits 7:0. Entries reach `cmd_o` in the order they were written.
- R2: A host read of offset 0x10 returns the oldest received byte in bits 7:0 of `reg_rdata_o` one cycle after the read strobe, and removes that byte from the receive queue.
- R3: A host write to offset 0x10 while the command queue holds TX_DEPTH entries is dropped. `tx_over_o` is high for the one cycle after that write, and the queue contents are unchanged.
- R4: A `rx_push_i` while the receive queue holds RX_DEPTH bytes is dropped, and `rx_over_o` is high for the one cycle after it.
- R5: A host read of offset 0x10 while the receive queue is empty returns 0, and `rx_under_o` is high for the one cycle after it.
- R6: Offset 0x74 reads the command queue fill level and offset 0x78 reads the receive queue fill level. Neither level ever exceeds its depth.
- R7: Offset 0x3C holds the transmit threshold and offset 0x38 holds the receive threshold, each 8 bits wide. Both are written by the host, read back, and reset to 0.
- R8: `tx_empty_o` is high exactly while the command queue level is less than or equal to the transmit threshold.
- R9: `rx_full_o` is high exactly while the receive queue level is greater than the receive threshold, so a threshold of 0 flags a single byte.
- R10: `abort_i` empties both queues on the next clock edge. A host write or an `rx_push_i` in the same cycle is discarded.
- R11: Offset 0xF4 reads TX_DEPTH-1 in bits 23:16 and RX_DEPTH-1 in bits 15:8. All other bits read 0.
- R12: Offset 0x70 reads a status word. Bit 0 is `bus_active_i`, bit 1 is "command queue not full", bit 2 is "command queue empty", bit 3 is "receive queue not empty", bit 4 is "receive queue full", and the upper bits are 0.
- R13: After reset both queues are empty, `cmd_valid_o` is low, `tx_empty_o` is high, `rx_full_o` and the three event pulses are low.
- R14: `cmd_valid_o` is high while the command queue is non-empty. A `cmd_pop_i` while it is high removes the head entry, and a `cmd_pop_i` on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_rd_i | input | 1 | Host register read strobe |
| reg_addr_i | input | 8 | Host register byte offset |
| reg_wdata_i | input | 9 | Host write data (bit 8 is the receive-request flag at 0x10) |
| reg_rdata_o | output | 32 | Registered host read data, valid the cycle after `reg_rd_i` |
| cmd_valid_o | output | 1 | Command queue head is valid |
| cmd_o | output | 9 | Command queue head entry |
| cmd_pop_i | input | 1 | Bus engine consumes the head entry |
| rx_push_i | input | 1 | Bus engine delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| abort_i | input | 1 | Transfer abort, empties both queues |
| bus_active_i | input | 1 | Bus activity indication for the status word |
| tx_empty_o | output | 1 | Command queue at or below its threshold |
| rx_full_o | output | 1 | Receive queue above its threshold |
| tx_over_o | output | 1 | One-cycle pulse: host write dropped |
| rx_over_o | output | 1 | One-cycle pulse: received byte dropped |
| rx_under_o | output | 1 | One-cycle pulse: read of empty receive queue |

## Verification
Queue levels change on the clock edge that samples a write, push, pop or abort. `tx_empty_o`, `rx_full_o` and `cmd_valid_o` are decoded from those levels, so they are valid in the cycle right after that edge. Read data and the three event pulses pass through one more register stage, so they appear in the cycle after the strobe and the pulses last only that one cycle. The bench drives every strobe for exactly one cycle starting on a falling edge. It samples at the next falling edge, which is the middle of the cycle in which each result is due. It also checks one cycle later that the pulses have dropped. The threshold sweeps cover every threshold from 0 to the depth against every fill level, on a small non-power-of-two receive depth so that pointer wrap is exercised.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam logic [7:0] OFS_DATA   = 8'h10;
  localparam logic [7:0] OFS_RX_THR = 8'h38;
  localparam logic [7:0] OFS_TX_THR = 8'h3C;
  localparam logic [7:0] OFS_STATUS = 8'h70;
  localparam logic [7:0] OFS_TX_LVL = 8'h74;
  localparam logic [7:0] OFS_RX_LVL = 8'h78;
  localparam logic [7:0] OFS_PARAM  = 8'hF4;

  // queued command: rd set = receive request, else transmit byte
  typedef struct packed {
    logic       rd;
    logic [7:0] data;
  } cmd_t;

  localparam int unsigned CMD_W = $bits(cmd_t);
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          drop_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt == LW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign drop_o  = push_i && full_o && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + LW'(1);
        2'b01:   cnt <= cnt - LW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  assign rdata_o = mem[rd_ptr];
  assign level_o = cnt;
endmodule

// File: rtl/i2cq_flags.sv
module i2cq_flags #(
  parameter int unsigned TX_LW = 4,
  parameter int unsigned RX_LW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TX_LW-1:0] tx_lvl_i,
  input  logic [RX_LW-1:0] rx_lvl_i,
  input  logic [7:0]       tx_thr_i,
  input  logic [7:0]       rx_thr_i,
  input  logic             tx_drop_i,
  input  logic             rx_drop_i,
  input  logic             rx_under_i,
  output logic             tx_empty_o,
  output logic             rx_full_o,
  output logic             tx_over_o,
  output logic             rx_over_o,
  output logic             rx_under_o
);
  // compare at 9 bits so a depth of 256 still fits
  always_comb begin
    tx_empty_o = (9'(tx_lvl_i) <= {1'b0, tx_thr_i});
    rx_full_o  = (9'(rx_lvl_i) >  {1'b0, rx_thr_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_over_o  <= 1'b0;
      rx_over_o  <= 1'b0;
      rx_under_o <= 1'b0;
    end else begin
      tx_over_o  <= tx_drop_i;
      rx_over_o  <= rx_drop_i;
      rx_under_o <= rx_under_i;
    end
  end
endmodule

// File: rtl/i2cq_host_if.sv
module i2cq_host_if
  import i2cq_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [8:0]  reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        cmd_valid_o,
  output logic [8:0]  cmd_o,
  input  logic        cmd_pop_i,
  input  logic        rx_push_i,
  input  logic [7:0]  rx_data_i,
  input  logic        abort_i,
  input  logic        bus_active_i,
  output logic        tx_empty_o,
  output logic        rx_full_o,
  output logic        tx_over_o,
  output logic        rx_over_o,
  output logic        rx_under_o
);
  localparam int unsigned TX_LW = $clog2(TX_DEPTH + 1);
  localparam int unsigned RX_LW = $clog2(RX_DEPTH + 1);
  localparam logic [31:0] PARAM_WORD =
    {8'h00, 8'(TX_DEPTH - 1), 8'(RX_DEPTH - 1), 8'h00};

  logic             wr_data, rd_data;
  cmd_t             tx_head;
  logic [TX_LW-1:0] tx_lvl;
  logic [RX_LW-1:0] rx_lvl;
  logic             tx_full, tx_fempty, tx_drop;
  logic             rx_ffull, rx_fempty, rx_drop;
  logic [7:0]       rx_head;
  logic [7:0]       tx_thr, rx_thr;
  logic [31:0]      rd_mux;

  assign wr_data = reg_wr_i && (reg_addr_i == OFS_DATA);
  assign rd_data = reg_rd_i && (reg_addr_i == OFS_DATA);

  i2cq_fifo #(.DW(CMD_W), .DEPTH(TX_DEPTH), .LW(TX_LW)) u_txq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (abort_i),
    .push_i  (wr_data),
    .wdata_i (reg_wdata_i),
    .pop_i   (cmd_pop_i),
    .rdata_o (tx_head),
    .level_o (tx_lvl),
    .full_o  (tx_full),
    .empty_o (tx_fempty),
    .drop_o  (tx_drop)
  );

  i2cq_fifo #(.DW(8), .DEPTH(RX_DEPTH), .LW(RX_LW)) u_rxq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (abort_i),
    .push_i  (rx_push_i),
    .wdata_i (rx_data_i),
    .pop_i   (rd_data),
    .rdata_o (rx_head),
    .level_o (rx_lvl),
    .full_o  (rx_ffull),
    .empty_o (rx_fempty),
    .drop_o  (rx_drop)
  );

  i2cq_flags #(.TX_LW(TX_LW), .RX_LW(RX_LW)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_lvl_i   (tx_lvl),
    .rx_lvl_i   (rx_lvl),
    .tx_thr_i   (tx_thr),
    .rx_thr_i   (rx_thr),
    .tx_drop_i  (tx_drop),
    .rx_drop_i  (rx_drop),
    .rx_under_i (rd_data && rx_fempty),
    .tx_empty_o (tx_empty_o),
    .rx_full_o  (rx_full_o),
    .tx_over_o  (tx_over_o),
    .rx_over_o  (rx_over_o),
    .rx_under_o (rx_under_o)
  );

  assign cmd_valid_o = !tx_fempty;
  assign cmd_o       = tx_head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_thr <= '0;
      rx_thr <= '0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == OFS_TX_THR) tx_thr <= reg_wdata_i[7:0];
      if (reg_addr_i == OFS_RX_THR) rx_thr <= reg_wdata_i[7:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      OFS_DATA:   rd_mux = rx_fempty ? '0 : 32'(rx_head);
      OFS_RX_THR: rd_mux = 32'(rx_thr);
      OFS_TX_THR: rd_mux = 32'(tx_thr);
      OFS_STATUS: rd_mux = {27'd0, rx_ffull, !rx_fempty, tx_fempty, !tx_full, bus_active_i};
      OFS_TX_LVL: rd_mux = 32'(tx_lvl);
      OFS_RX_LVL: rd_mux = 32'(rx_lvl);
      OFS_PARAM:  rd_mux = PARAM_WORD;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/i2cq_chk.sv
module i2cq_chk #(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8,
  parameter int unsigned TX_LW    = 4,
  parameter int unsigned RX_LW    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic             reg_rd_i,
  input logic [7:0]       reg_addr_i,
  input logic [31:0]      reg_rdata_o,
  input logic             cmd_pop_i,
  input logic             rx_push_i,
  input logic             abort_i,
  input logic [TX_LW-1:0] tx_lvl,
  input logic [RX_LW-1:0] rx_lvl,
  input logic             tx_over_o,
  input logic             rx_over_o,
  input logic             rx_under_o
);
  localparam logic [7:0] DATA_OFS = 8'h10;

  assert_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (tx_lvl == '0 && rx_lvl == '0));

  assert_tx_over_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == DATA_OFS && tx_lvl == TX_LW'(TX_DEPTH) && !abort_i)
      |=> tx_over_o);

  assert_rx_over_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_lvl == RX_LW'(RX_DEPTH) && !abort_i) |=> rx_over_o);

  assert_rx_under_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == DATA_OFS && rx_lvl == '0)
      |=> (rx_under_o && reg_rdata_o == '0));

  assert_lvl_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_lvl <= TX_LW'(TX_DEPTH)) && (rx_lvl <= RX_LW'(RX_DEPTH)));

  assert_pop_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_pop_i && tx_lvl != '0 && !abort_i && !reg_wr_i)
      |=> (tx_lvl == $past(tx_lvl) - TX_LW'(1)));
endmodule

bind i2cq_host_if i2cq_chk #(
  .TX_DEPTH (TX_DEPTH),
  .RX_DEPTH (RX_DEPTH),
  .TX_LW    (TX_LW),
  .RX_LW    (RX_LW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .cmd_pop_i   (cmd_pop_i),
  .rx_push_i   (rx_push_i),
  .abort_i     (abort_i),
  .tx_lvl      (tx_lvl),
  .rx_lvl      (rx_lvl),
  .tx_over_o   (tx_over_o),
  .rx_over_o   (rx_over_o),
  .rx_under_o  (rx_under_o)
);

// File: tb/sim_i2cq_host_if.sv
`timescale 1ns/1ps
module sim_i2cq_host_if;
  localparam int TXD = 4;
  localparam int RXD = 6;
  localparam logic [7:0] A_DATA = 8'h10, A_RXT = 8'h38, A_TXT = 8'h3C,
                         A_STAT = 8'h70, A_TXL = 8'h74, A_RXL = 8'h78, A_PAR = 8'hF4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [8:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cmd_valid;
  logic [8:0] cmd;
  logic cmd_pop = 1'b0, rx_push = 1'b0, abort = 1'b0, bus_active = 1'b0;
  logic [7:0] rx_data = '0;
  logic tx_empty, rx_full, tx_over, rx_over, rx_under;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  i2cq_host_if #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_pop_i(cmd_pop),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .abort_i(abort),
    .bus_active_i(bus_active), .tx_empty_o(tx_empty), .rx_full_o(rx_full),
    .tx_over_o(tx_over), .rx_over_o(rx_over), .rx_under_o(rx_under)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [8:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic eng_pop(output logic v, output logic [8:0] c);
    @(negedge clk); v = cmd_valid; c = cmd; cmd_pop = 1'b1;
    @(negedge clk); cmd_pop = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] b);
    @(negedge clk); rx_push = 1'b1; rx_data = b;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic v;
    logic [8:0] c;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13 tx_empty", 32'(tx_empty), 1);
    chk("R13 rx_full", 32'(rx_full), 0);
    chk("R13 cmd_valid", 32'(cmd_valid), 0);
    chk("R13 pulses", {29'd0, tx_over, rx_over, rx_under}, 0);
    host_rd(A_TXL, d); chk("R13 tx level", d, 0);
    host_rd(A_RXL, d); chk("R13 rx level", d, 0);
    host_rd(A_TXT, d); chk("R7 tx thr reset", d, 0);
    host_rd(A_RXT, d); chk("R7 rx thr reset", d, 0);

    // R11 parameter word
    host_rd(A_PAR, d); chk("R11 param", d, ((TXD - 1) << 16) | ((RXD - 1) << 8));

    // R12 status with empty queues
    bus_active = 1'b1;
    host_rd(A_STAT, d); chk("R12 status active", d, 32'h07);
    bus_active = 1'b0;
    host_rd(A_STAT, d); chk("R12 status idle", d, 32'h06);

    // R1 mixed write and receive-request entries, order kept
    host_wr(A_DATA, 9'h05A);
    host_wr(A_DATA, 9'h1A5);
    host_wr(A_DATA, 9'h0C3);
    host_rd(A_TXL, d); chk("R6 tx level 3", d, 3);
    eng_pop(v, c); chk("R14 valid", 32'(v), 1); chk("R1 entry0", 32'(c), 32'h05A);
    eng_pop(v, c); chk("R1 entry1 rd", 32'(c), 32'h1A5);
    eng_pop(v, c); chk("R1 entry2", 32'(c), 32'h0C3);
    chk("R14 valid after drain", 32'(cmd_valid), 0);
    // R14 pop on empty queue has no effect
    eng_pop(v, c);
    host_rd(A_TXL, d); chk("R14 empty pop level", d, 0);

    // R3 command queue overflow
    for (int i = 0; i < TXD; i++) begin
      host_wr(A_DATA, 9'(8'h10 + i));
      chk("R3 no over while filling", 32'(tx_over), 0);
    end
    host_wr(A_DATA, 9'h0EE);
    chk("R3 over pulse", 32'(tx_over), 1);
    @(negedge clk);
    chk("R3 over pulse ends", 32'(tx_over), 0);
    host_rd(A_TXL, d); chk("R3 level held", d, TXD);
    host_rd(A_STAT, d); chk("R12 status tx full", d, 32'h00);
    for (int i = 0; i < TXD; i++) begin
      eng_pop(v, c); chk("R3 contents kept", 32'(c), 32'(8'h10 + i));
    end
    chk("R3 dropped entry absent", 32'(cmd_valid), 0);

    // R4 receive overflow, R2 ordered reads
    for (int i = 0; i <= RXD; i++) eng_push(8'(8'h80 + i));
    chk("R4 over pulse", 32'(rx_over), 1);
    host_rd(A_RXL, d); chk("R6 rx level full", d, RXD);
    chk("R4 over pulse ends", 32'(rx_over), 0);
    host_rd(A_STAT, d); chk("R12 status rx full", d, 32'h1E);
    for (int i = 0; i < RXD; i++) begin
      host_rd(A_DATA, d); chk("R2 rx byte order", d, 32'(8'h80 + i));
    end
    host_rd(A_RXL, d); chk("R2 rx drained", d, 0);

    // R5 underflow
    host_rd(A_DATA, d);
    chk("R5 empty read data", d, 0);
    chk("R5 under pulse", 32'(rx_under), 1);
    @(negedge clk);
    chk("R5 under pulse ends", 32'(rx_under), 0);

    // R10 abort flushes, same-cycle push and write discarded
    host_wr(A_DATA, 9'h011);
    host_wr(A_DATA, 9'h022);
    eng_push(8'h33); eng_push(8'h44); eng_push(8'h55);
    @(negedge clk);
    abort = 1'b1; rx_push = 1'b1; rx_data = 8'h66; reg_wr = 1'b1;
    reg_addr = A_DATA; reg_wdata = 9'h077;
    @(negedge clk);
    abort = 1'b0; rx_push = 1'b0; reg_wr = 1'b0;
    chk("R10 cmd_valid", 32'(cmd_valid), 0);
    chk("R10 no over", 32'(tx_over), 0);
    host_rd(A_TXL, d); chk("R10 tx level", d, 0);
    host_rd(A_RXL, d); chk("R10 rx level", d, 0);

    // R7 threshold read back
    host_wr(A_TXT, 9'h0A2); host_wr(A_RXT, 9'h1C3);
    host_rd(A_TXT, d); chk("R7 tx thr", d, 32'hA2);
    host_rd(A_RXT, d); chk("R7 rx thr", d, 32'hC3);

    // R8 sweep: every tx threshold against every level
    for (int thr = 0; thr <= TXD; thr++) begin
      host_wr(A_TXT, 9'(thr));
      do_abort();
      for (int k = 0; k <= TXD; k++) begin
        chk("R8 tx_empty", 32'(tx_empty), (k <= thr) ? 1 : 0);
        if (thr == 0) begin
          host_rd(A_TXL, d); chk("R6 tx level sweep", d, k);
        end
        if (k < TXD) host_wr(A_DATA, 9'(k));
      end
    end

    // R9 sweep: every rx threshold against every level
    for (int thr = 0; thr <= RXD; thr++) begin
      host_wr(A_RXT, 9'(thr));
      do_abort();
      for (int k = 0; k <= RXD; k++) begin
        chk("R9 rx_full", 32'(rx_full), (k > thr) ? 1 : 0);
        if (thr == 0) begin
          host_rd(A_RXL, d); chk("R6 rx level sweep", d, k);
        end
        if (k < RXD) eng_push(8'(k));
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule